// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer whose write side and read side each run on their own clock. The two clocks may be the same net or fully unrelated. Words are `WIDTH` bits wide (9 by default) and the number of stored words is set by `DEPTH`. Each side has two active-low enables that must both be asserted for a transfer. Four active-low flags report the fill state: empty and near-empty belong to the read clock, full and near-full belong to the write clock.

The near-empty and near-full thresholds are held in two offset registers that reset to `DEPTH/8`. One write-side pin, `wr_aux_n`, has two possible roles and the level it has during reset picks one. When it is high during reset, it acts afterwards as a second active-low write enable. When it is low during reset, it acts afterwards as a load strobe: an enabled write-clock edge with the pin low writes the input word into the offset registers, while an enabled edge with the pin high stores FIFO data as usual. Offset loads go through a fixed cycle of four fields that wraps. Pointers cross between the clock domains in Gray code through a chain of synchronizer flops, and each flag is computed from the local pointer and the synchronized remote pointer.

Top module: `dc_fifo_progflag`

## Requirements
- R1: While `rst_n` is low and after its release, before any transfer, `empty_n`=0, `near_empty_n`=0, `full_n`=1, `near_full_n`=1, and both offsets equal `DEPTH/8`.
- R2: In enable mode (`wr_aux_n` high during reset), a word is stored on a rising `wr_clk` edge only when `wr_en_a_n`=0 and `wr_aux_n`=0. Either enable high alone stores nothing.
- R3: A write attempted while `full_n`=0 is ignored, and the stored contents and their order are unchanged.
- R4: A read happens on a rising `rd_clk` edge only when `rd_en_a_n`=0, `rd_en_b_n`=0 and `empty_n`=1. Otherwise `dout` keeps its value and no word is consumed.
- R5: Words leave in the order they were written. `dout` takes the word read at a read edge right after that edge, so the first word written into an empty FIFO appears one read cycle after the read that follows the rise of `empty_n`.
- R6: `full_n` is 0 exactly when the write-side count of unread words equals `DEPTH`.
- R7: `near_full_n` is 0 when the write-side count is at least `DEPTH` minus the near-full offset, and it is 1 once the free locations exceed that offset.
- R8: `empty_n` is 0 when the read-side count is zero. `near_empty_n` is 0 when that count is at most the near-empty offset.
- R9: The level of `wr_aux_n` during reset sets its role until the next reset. In load mode, an enabled edge (`wr_en_a_n`=0) with `wr_aux_n`=1 stores FIFO data.
- R10: In load mode, each edge with `wr_en_a_n`=0 and `wr_aux_n`=0 writes `din` to the next offset field in the cycle: near-empty bits [W-1:0], near-empty bits [2W-1:W], near-full bits [W-1:0], near-full bits [2W-1:W], then back to the first. No FIFO data is stored on such an edge.
- R11: Empty and near-empty change only on `rd_clk` edges, and full and near-full change only on `wr_clk` edges. A transfer on the other side is reflected within `SYNC_STAGES`+1 edges of the flag's own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en_a_n | input | 1 | First write enable, active low |
| wr_aux_n | input | 1 | Dual-role pin: second write enable or offset load strobe, role chosen during reset |
| din | input | WIDTH | Write data or offset field value |
| rd_en_a_n | input | 1 | First read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| dout | output | WIDTH | Registered read data |
| empty_n | output | 1 | Empty flag, active low, read clock |
| near_empty_n | output | 1 | Programmable near-empty flag, active low, read clock |
| near_full_n | output | 1 | Programmable near-full flag, active low, write clock |
| full_n | output | 1 | Full flag, active low, write clock |

## Verification
A corrupted write or read pointer shows up as a wrong word or a wrong order on `dout` at the next read. It also shifts the fill count, which moves the level flags one word away from their thresholds once the Gray pointer has crossed, a few edges later. A wrong mode latch or load step moves a threshold. That error is only visible when the fill level passes that threshold, so the bench fills the FIFO to the exact boundary counts after loading, and a field written in the wrong order changes the flag at the wrong count. Flags are compared only after both clocks have run long enough for the synchronizers to settle, and data is compared on every read.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

   // role taken by the dual-purpose write pin, fixed while reset is low
   typedef enum logic {
      MODE_ENABLE = 1'b0,
      MODE_LOAD   = 1'b1
   } pin_mode_e;

   // offset field written by the next load strobe
   typedef enum logic [1:0] {
      LD_NE_LO = 2'd0,
      LD_NE_HI = 2'd1,
      LD_NF_LO = 2'd2,
      LD_NF_HI = 2'd3
   } ld_step_e;

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[gi] <= '0;
               else        stg[gi] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[gi] <= '0;
               else        stg[gi] <= stg[gi-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
   parameter int WIDTH = 9,
   parameter int AW    = 6
) (
   input  logic             wr_clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             rd_clk,
   input  logic             rst_n,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   localparam int WORDS = 1 << AW;

   logic [WIDTH-1:0] ram [WORDS];

   always_ff @(posedge wr_clk) begin
      if (we) ram[waddr] <= wdata;
   end

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= ram[raddr];
   end

endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
   import dcf_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int WIDTH = 9,
   localparam int AW = $clog2(DEPTH),
   localparam int PW = AW + 1,
   localparam int OW = 2 * WIDTH
) (
   input  logic             wr_clk,
   input  logic             rst_n,
   input  logic             wr_en_a_n,
   input  logic             wr_aux_n,
   input  logic [WIDTH-1:0] din,
   input  logic [PW-1:0]    rgray_s,
   output logic [PW-1:0]    wgray,
   output logic             mem_we,
   output logic [AW-1:0]    waddr,
   output logic [OW-1:0]    ne_ofs,
   output logic             full_n,
   output logic             near_full_n
);

   localparam int CW = OW + 1;
   localparam logic [OW-1:0] OFS_DEF = OW'(DEPTH / 8);

   pin_mode_e      mode_q;
   logic [1:0]     step_q;
   logic [OW-1:0]  nf_ofs;
   logic [PW-1:0]  wptr_q, wptr_nxt, rbin, wcount;
   logic [CW-1:0]  fill_sum;
   logic           data_req, ld_req, do_write;

   // role of the dual pin: captured on every write edge while reset is low
   always_ff @(posedge wr_clk) begin
      if (!rst_n) mode_q <= wr_aux_n ? MODE_ENABLE : MODE_LOAD;
   end

   always_comb begin
      data_req = !wr_en_a_n && ((mode_q == MODE_ENABLE) ? !wr_aux_n : wr_aux_n);
      ld_req   = (mode_q == MODE_LOAD) && !wr_en_a_n && !wr_aux_n;
   end

   assign do_write = data_req && full_n;
   assign wptr_nxt = wptr_q + PW'(do_write);

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         wgray  <= '0;
      end else begin
         wptr_q <= wptr_nxt;
         wgray  <= wptr_nxt ^ (wptr_nxt >> 1);
      end
   end

   // Gray to binary for the synchronized read pointer
   genvar gi;
   generate
      for (gi = 0; gi < PW; gi++) begin : g_g2b
         assign rbin[gi] = ^(rgray_s >> gi);
      end
   endgenerate

   always_comb begin
      wcount      = wptr_q - rbin;
      full_n      = (wcount != PW'(DEPTH));
      fill_sum    = CW'(wcount) + CW'(nf_ofs);
      near_full_n = (fill_sum < CW'(DEPTH));
   end

   // offset registers, written in a fixed four-field cycle
   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         ne_ofs <= OFS_DEF;
         nf_ofs <= OFS_DEF;
         step_q <= 2'd0;
      end else if (ld_req) begin
         step_q <= step_q + 2'd1;
         case (ld_step_e'(step_q))
            LD_NE_LO: ne_ofs[WIDTH-1:0]  <= din;
            LD_NE_HI: ne_ofs[OW-1:WIDTH] <= din;
            LD_NF_LO: nf_ofs[WIDTH-1:0]  <= din;
            default:  nf_ofs[OW-1:WIDTH] <= din;
         endcase
      end
   end

   assign mem_we = do_write;
   assign waddr  = wptr_q[AW-1:0];

   p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !full_n |=> $stable(wptr_q));
   p_count_bound_r6: assert property (@(posedge wr_clk) disable iff (!rst_n)
      wcount <= PW'(DEPTH));
   p_full_is_near_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !full_n |-> !near_full_n);
   p_mode_frozen_r9: assert property (@(posedge wr_clk) disable iff (!rst_n)
      1'b1 |=> $stable(mode_q));
   p_load_cycle_r10: assert property (@(posedge wr_clk) disable iff (!rst_n)
      ld_req |=> (step_q == $past(step_q) + 2'd1));
   p_load_no_data_r10: assert property (@(posedge wr_clk) disable iff (!rst_n)
      ld_req |=> $stable(wptr_q));

endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
   parameter int DEPTH = 64,
   parameter int WIDTH = 9,
   localparam int AW = $clog2(DEPTH),
   localparam int PW = AW + 1,
   localparam int OW = 2 * WIDTH
) (
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic          rd_en_a_n,
   input  logic          rd_en_b_n,
   input  logic [PW-1:0] wgray_s,
   input  logic [OW-1:0] ne_ofs,
   output logic [PW-1:0] rgray,
   output logic          mem_re,
   output logic [AW-1:0] raddr,
   output logic          empty_n,
   output logic          near_empty_n
);

   localparam int CW = OW + 1;

   logic [PW-1:0] rptr_q, rptr_nxt, wbin, rcount;
   logic          do_read;

   genvar gi;
   generate
      for (gi = 0; gi < PW; gi++) begin : g_g2b
         assign wbin[gi] = ^(wgray_s >> gi);
      end
   endgenerate

   always_comb begin
      rcount       = wbin - rptr_q;
      empty_n      = (rcount != '0);
      near_empty_n = !(CW'(rcount) <= CW'(ne_ofs));
   end

   assign do_read  = !rd_en_a_n && !rd_en_b_n && empty_n;
   assign rptr_nxt = rptr_q + PW'(do_read);

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr_q <= '0;
         rgray  <= '0;
      end else begin
         rptr_q <= rptr_nxt;
         rgray  <= rptr_nxt ^ (rptr_nxt >> 1);
      end
   end

   assign mem_re = do_read;
   assign raddr  = rptr_q[AW-1:0];

   p_no_underflow_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !empty_n |=> $stable(rptr_q));
   p_empty_is_near_r8: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !empty_n |-> !near_empty_n);
   p_rcount_bound_r8: assert property (@(posedge rd_clk) disable iff (!rst_n)
      rcount <= PW'(DEPTH));

endmodule

// File: rtl/dc_fifo_progflag.sv
module dc_fifo_progflag #(
   parameter int DEPTH       = 64,
   parameter int WIDTH       = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic             wr_clk,
   input  logic             rd_clk,
   input  logic             rst_n,
   input  logic             wr_en_a_n,
   input  logic             wr_aux_n,
   input  logic [WIDTH-1:0] din,
   input  logic             rd_en_a_n,
   input  logic             rd_en_b_n,
   output logic [WIDTH-1:0] dout,
   output logic             empty_n,
   output logic             near_empty_n,
   output logic             near_full_n,
   output logic             full_n
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;
   localparam int OW = 2 * WIDTH;

   generate
      if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two and at least 8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (OW < PW) begin : g_bad_width
         $error("two data words must cover the fill count");
      end
   endgenerate

   logic [PW-1:0] wgray, wgray_s, rgray, rgray_s;
   logic [OW-1:0] ne_ofs;
   logic [AW-1:0] waddr, raddr;
   logic          mem_we, mem_re;

   dcf_wr_side #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_wr (
      .wr_clk      (wr_clk),
      .rst_n       (rst_n),
      .wr_en_a_n   (wr_en_a_n),
      .wr_aux_n    (wr_aux_n),
      .din         (din),
      .rgray_s     (rgray_s),
      .wgray       (wgray),
      .mem_we      (mem_we),
      .waddr       (waddr),
      .ne_ofs      (ne_ofs),
      .full_n      (full_n),
      .near_full_n (near_full_n)
   );

   dcf_rd_side #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rd (
      .rd_clk       (rd_clk),
      .rst_n        (rst_n),
      .rd_en_a_n    (rd_en_a_n),
      .rd_en_b_n    (rd_en_b_n),
      .wgray_s      (wgray_s),
      .ne_ofs       (ne_ofs),
      .rgray        (rgray),
      .mem_re       (mem_re),
      .raddr        (raddr),
      .empty_n      (empty_n),
      .near_empty_n (near_empty_n)
   );

   dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk   (rd_clk),
      .rst_n (rst_n),
      .d     (wgray),
      .q     (wgray_s)
   );

   dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk   (wr_clk),
      .rst_n (rst_n),
      .d     (rgray),
      .q     (rgray_s)
   );

   dcf_mem #(.WIDTH(WIDTH), .AW(AW)) u_mem (
      .wr_clk (wr_clk),
      .we     (mem_we),
      .waddr  (waddr),
      .wdata  (din),
      .rd_clk (rd_clk),
      .rst_n  (rst_n),
      .re     (mem_re),
      .raddr  (raddr),
      .rdata  (dout)
   );

   p_dout_hold_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_en_a_n || rd_en_b_n || !empty_n) |=> $stable(dout));
   p_gray_step_r11: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $countones(wgray ^ $past(wgray)) <= 1);

endmodule

// File: tb/tb_dc_fifo_progflag.sv
module tb_dc_fifo_progflag;

   localparam int DEPTH = 16;
   localparam int WIDTH = 9;
   localparam int WPER  = 10;
   localparam int RPER  = 14;

   logic             wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
   logic             wr_en_a_n = 1'b1, wr_aux_n = 1'b1;
   logic [WIDTH-1:0] din = '0;
   logic             rd_en_a_n = 1'b1, rd_en_b_n = 1'b1;
   logic [WIDTH-1:0] dout;
   logic             empty_n, near_empty_n, near_full_n, full_n;

   int n_tests = 0;
   int n_fail  = 0;
   int seq     = 0;
   logic [WIDTH-1:0] model [$];
   logic [WIDTH-1:0] last_out = '0;

   always #(WPER/2) wr_clk = ~wr_clk;
   always #(RPER/2) rd_clk = ~rd_clk;

   dc_fifo_progflag #(.DEPTH(DEPTH), .WIDTH(WIDTH), .SYNC_STAGES(2)) dut (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
      .wr_en_a_n(wr_en_a_n), .wr_aux_n(wr_aux_n), .din(din),
      .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n), .dout(dout),
      .empty_n(empty_n), .near_empty_n(near_empty_n),
      .near_full_n(near_full_n), .full_n(full_n)
   );

   typedef struct packed {
      logic [7:0] nw;
      logic [7:0] nr;
      logic       e;
      logic       ne;
      logic       nf;
      logic       f;
   } vec_t;

   // default offsets are DEPTH/8 = 2: near-empty at count<=2, near-full at count>=14
   localparam vec_t VECS [10] = '{
      '{8'd1,  8'd0,  1'b1, 1'b0, 1'b1, 1'b1},   // 1 word
      '{8'd2,  8'd0,  1'b1, 1'b1, 1'b1, 1'b1},   // 3
      '{8'd11, 8'd0,  1'b1, 1'b1, 1'b0, 1'b1},   // 14
      '{8'd2,  8'd0,  1'b1, 1'b1, 1'b0, 1'b0},   // 16 full
      '{8'd1,  8'd0,  1'b1, 1'b1, 1'b0, 1'b0},   // write while full dropped
      '{8'd0,  8'd1,  1'b1, 1'b1, 1'b0, 1'b1},   // 15
      '{8'd0,  8'd2,  1'b1, 1'b1, 1'b1, 1'b1},   // 13
      '{8'd0,  8'd11, 1'b1, 1'b0, 1'b1, 1'b1},   // 2
      '{8'd0,  8'd2,  1'b0, 1'b0, 1'b1, 1'b1},   // 0 empty
      '{8'd0,  8'd1,  1'b0, 1'b0, 1'b1, 1'b1}    // read on empty ignored
   };

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic flags(input string req, input logic e, input logic ne, input logic nf, input logic f);
      chk(req, "empty_n", 32'(empty_n), 32'(e));
      chk(req, "near_empty_n", 32'(near_empty_n), 32'(ne));
      chk(req, "near_full_n", 32'(near_full_n), 32'(nf));
      chk(req, "full_n", 32'(full_n), 32'(f));
   endtask

   task automatic settle();
      repeat (5) @(negedge wr_clk);
      repeat (5) @(negedge rd_clk);
   endtask

   // one enabled write edge; aux_lvl is the level the dual pin takes for a data write
   task automatic push(input logic aux_lvl);
      logic [WIDTH-1:0] d;
      seq++;
      d = WIDTH'(seq * 37 + 5);
      @(negedge wr_clk);
      wr_en_a_n = 1'b0; wr_aux_n = aux_lvl; din = d;
      @(negedge wr_clk);
      wr_en_a_n = 1'b1; wr_aux_n = 1'b1;
      if (model.size() < DEPTH) model.push_back(d);
   endtask

   task automatic load(input logic [WIDTH-1:0] v);
      @(negedge wr_clk);
      wr_en_a_n = 1'b0; wr_aux_n = 1'b0; din = v;
      @(negedge wr_clk);
      wr_en_a_n = 1'b1; wr_aux_n = 1'b1;
   endtask

   task automatic pop();
      @(negedge rd_clk);
      rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
      @(negedge rd_clk);
      rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
      if (model.size() > 0) last_out = model.pop_front();
      chk("R5/R3", "dout", 32'(dout), 32'(last_out));
   endtask

   task automatic do_reset(input logic aux_lvl);
      @(negedge wr_clk);
      rst_n = 1'b0; wr_aux_n = aux_lvl; wr_en_a_n = 1'b1;
      repeat (4) @(negedge wr_clk);
      repeat (2) @(negedge rd_clk);
      flags("R1 in reset", 1'b0, 1'b0, 1'b1, 1'b1);
      chk("R1", "dout in reset", 32'(dout), 32'h0);
      @(negedge wr_clk);
      #1 rst_n = 1'b1;
      wr_aux_n = 1'b1;
      model.delete();
      last_out = '0;
   endtask

   initial begin
      #(WPER * 150000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // enable mode
      do_reset(1'b1);
      settle();
      flags("R1 after release", 1'b0, 1'b0, 1'b1, 1'b1);

      foreach (VECS[i]) begin
         for (int k = 0; k < int'(VECS[i].nw); k++) push(1'b0);
         for (int k = 0; k < int'(VECS[i].nr); k++) pop();
         settle();
         flags($sformatf("R6/R7/R8/R11 vec%0d", i), VECS[i].e, VECS[i].ne, VECS[i].nf, VECS[i].f);
      end

      // R2: only one write enable low stores nothing
      @(negedge wr_clk); wr_en_a_n = 1'b0; wr_aux_n = 1'b1;
      @(negedge wr_clk); wr_en_a_n = 1'b1;
      @(negedge wr_clk); wr_aux_n = 1'b0;
      @(negedge wr_clk); wr_aux_n = 1'b1;
      settle();
      chk("R2", "empty_n after half-enabled writes", 32'(empty_n), 32'h0);

      push(1'b0);
      settle();
      chk("R2/R11", "empty_n after one write", 32'(empty_n), 32'h1);

      // R4: only one read enable low consumes nothing
      @(negedge rd_clk); rd_en_a_n = 1'b0;
      @(negedge rd_clk); rd_en_a_n = 1'b1; rd_en_b_n = 1'b0;
      @(negedge rd_clk); rd_en_b_n = 1'b1;
      settle();
      chk("R4", "empty_n after half-enabled reads", 32'(empty_n), 32'h1);
      chk("R4", "dout held", 32'(dout), 32'(last_out));
      pop();
      settle();
      chk("R8", "empty_n after last read", 32'(empty_n), 32'h0);

      // load mode: R9, R10
      do_reset(1'b0);
      load(9'd9);   // near-empty low field, later overwritten
      load(9'd0);   // near-empty high field
      load(9'd3);   // near-full low field
      load(9'd0);   // near-full high field
      load(9'd5);   // wraps to near-empty low field
      settle();
      chk("R10", "empty_n after loads", 32'(empty_n), 32'h0);

      for (int k = 0; k < 5; k++) push(1'b1);
      settle();
      chk("R9", "empty_n after load-mode data writes", 32'(empty_n), 32'h1);
      chk("R10", "near_empty_n at count 5, offset 5", 32'(near_empty_n), 32'h0);
      push(1'b1);
      settle();
      chk("R10", "near_empty_n at count 6", 32'(near_empty_n), 32'h1);
      for (int k = 0; k < 6; k++) push(1'b1);
      settle();
      chk("R7/R10", "near_full_n at count 12, offset 3", 32'(near_full_n), 32'h1);
      push(1'b1);
      settle();
      chk("R7/R10", "near_full_n at count 13", 32'(near_full_n), 32'h0);
      chk("R6", "full_n at count 13", 32'(full_n), 32'h1);
      pop();
      pop();
      settle();
      chk("R7", "near_full_n at count 11", 32'(near_full_n), 32'h1);

      // reset with data inside clears everything
      do_reset(1'b1);
      settle();
      flags("R1 reset with data", 1'b0, 1'b0, 1'b1, 1'b1);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule